// File: doc/BRIEF.md
# Suspend/Resume Timer Helper

This block is a bus-mapped peripheral for a soft system-on-chip. It holds a 64-bit count of milliseconds since boot that the operating system relies on for time keeping. It also coordinates the suspend/resume flow. Software raises a suspend/resume interrupt through a trigger bit. The interrupt handler then reads a reason field to learn whether it was entered for a suspend request or for a resume after reboot.

Before power is removed, software snapshots the counter into a capture register and stores it in battery-backed memory. After the reboot it writes that value into the capture register and into a 64-bit staging register. A load strobe then commits the staged value into the counter in one cycle. Once the block is armed, it refuses any restore value below the captured floor, so time never runs backwards across the power cycle.

The millisecond tick comes from a programmable divider of the system clock. The divider advances only while the clock-enable tick input is high. The bus has a one-cycle read latency.

Top module: `susres_timer`

## Requirements
- R1: After reset the counter reads 0, the status word (address 1) reads 0 and irq_o is low.
- R2: The divider advances on each cycle with tick_en_i high. The counter gains 1 every (DIV+1) such cycles, where DIV is the value written at address 8. With tick_en_i low the counter holds, and an accepted load restarts the divider from 0.
- R3: Writing 1 to control bit 0 (address 0) raises a one-cycle internal trigger. On the next cycle this sets status bit 0 (pending) and status bits [2:1] to 01 (suspend). irq_o follows the pending bit.
- R4: Writing 1 to status bit 0 clears pending and sets the reason to 00. Writing 0 there has no effect.
- R5: Writing 1 to control bit 1 commits the 64-bit staging register into the counter in a single cycle, with no increment in that cycle. The staging register is made of address 6 (bits 31:0) and address 7 (bits 63:32). An accepted load sets pending and sets the reason to 10 (resume).
- R6: A read of address 2 returns counter bits 31:0 and copies counter bits 63:32 into a shadow register. A read of address 3 returns that shadow, so a two-access read is consistent even if the counter moves in between.
- R7: Writing 1 to control bit 2 copies the counter into the capture register, which reads at address 4 (bits 31:0) and address 5 (bits 63:32). Software may also write both halves directly.
- R8: Writing 1 to control bit 3 sets the armed flag (status bit 4), which stays set until reset. While armed, a load whose staged value is below the capture register is refused. A refused load leaves the counter and reason unchanged and sets the error flag (status bit 3). A staged value equal to or above the capture register is accepted. Writing 1 to status bit 3 clears the error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_en_i | input | 1 | Clock enable for the millisecond divider |
| addr_i | input | AW (4) | Word address of the register access |
| wdata_i | input | DW (32) | Write data |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe; data appears on rdata_o the next cycle |
| rdata_o | output | DW (32) | Read data |
| irq_o | output | 1 | Suspend/resume interrupt, level |

## Verification
The assertions check four things on every cycle:
- Outside a load, the counter either holds or steps up by exactly one.
- A trigger is always followed by a raised interrupt, and an interrupt never stands with an empty reason.
- An accepted load lands the staged value the next cycle.
- The armed flag never falls, and an armed load never places the counter under the capture floor.

Only the bench scenarios can show the rest: the exact tick count for a given divider setting, the high-word shadow across a carry out of the low word, the write-one-to-clear behaviour including writes of zero, and a refused restore leaving the counter untouched while the error bit rises.

// File: rtl/susres_pkg.sv
package susres_pkg;
  localparam int A_CTRL   = 0;
  localparam int A_STAT   = 1;
  localparam int A_CNT_LO = 2;
  localparam int A_CNT_HI = 3;
  localparam int A_CAP_LO = 4;
  localparam int A_CAP_HI = 5;
  localparam int A_STG_LO = 6;
  localparam int A_STG_HI = 7;
  localparam int A_DIV    = 8;

  // control bit positions
  localparam int C_TRIG = 0;
  localparam int C_LOAD = 1;
  localparam int C_CAPT = 2;
  localparam int C_ARM  = 3;

  // status bit positions
  localparam int S_PEND  = 0;
  localparam int S_ERR   = 3;
  localparam int S_ARMED = 4;

  typedef enum logic [1:0] {
    RSN_NONE    = 2'b00,
    RSN_SUSPEND = 2'b01,
    RSN_RESUME  = 2'b10
  } reason_e;
endpackage

// File: rtl/susres_div.sv
module susres_div #(
  parameter int DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             clr_i,
  input  logic [DIV_W-1:0] period_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  // >= keeps the divider from running a full wrap if period is lowered
  assign tick_o = en_i && (cnt_q >= period_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (en_i) begin
      if (tick_o) cnt_q <= '0;
      else        cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/susres_cnt.sv
module susres_cnt #(
  parameter int CNT_W = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (load_i)  cnt_q <= load_val_i;   // load wins, tick dropped
    else if (tick_i)  cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/susres_ctrl.sv
module susres_ctrl
  import susres_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    trig_i,
  input  logic    load_ok_i,
  input  logic    load_rej_i,
  input  logic    clr_pend_i,
  input  logic    clr_err_i,
  input  logic    arm_i,
  output logic    pend_o,
  output reason_e reason_o,
  output logic    err_o,
  output logic    armed_o
);
  logic    pend_q, err_q, armed_q;
  reason_e reason_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q   <= 1'b0;
      reason_q <= RSN_NONE;
    end else if (trig_i) begin
      pend_q   <= 1'b1;
      reason_q <= RSN_SUSPEND;
    end else if (load_ok_i) begin
      pend_q   <= 1'b1;
      reason_q <= RSN_RESUME;
    end else if (clr_pend_i) begin
      pend_q   <= 1'b0;
      reason_q <= RSN_NONE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         err_q <= 1'b0;
    else if (load_rej_i) err_q <= 1'b1;
    else if (clr_err_i)  err_q <= 1'b0;
  end

  // write-once: only reset clears
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    armed_q <= 1'b0;
    else if (arm_i) armed_q <= 1'b1;
  end

  assign pend_o   = pend_q;
  assign reason_o = reason_q;
  assign err_o    = err_q;
  assign armed_o  = armed_q;
endmodule

// File: rtl/susres_timer.sv
module susres_timer
  import susres_pkg::*;
#(
  parameter int          DW      = 32,
  parameter int          AW      = 4,
  parameter int          DIV_W   = 16,
  parameter int unsigned DIV_RST = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          wr_i,
  input  logic          rd_i,
  output logic [DW-1:0] rdata_o,
  output logic          irq_o
);
  localparam int CNT_W  = 2 * DW;
  localparam int HALVES = CNT_W / DW;

  logic             wr_ctrl, wr_stat;
  logic             load_req, load_ok, load_rej, cap_now;
  logic             trig_q, ms_tick;
  logic [DIV_W-1:0] div_q;
  logic [CNT_W-1:0] cnt, cap_q, stage_q;
  logic [DW-1:0]    shadow_q, rdata_q, stat_w;
  logic             pend, err, armed;
  reason_e          reason;

  assign wr_ctrl  = wr_i && (addr_i == AW'(A_CTRL));
  assign wr_stat  = wr_i && (addr_i == AW'(A_STAT));
  assign load_req = wr_ctrl && wdata_i[C_LOAD];
  assign load_rej = load_req && armed && (stage_q < cap_q);
  assign load_ok  = load_req && !load_rej;
  assign cap_now  = wr_ctrl && wdata_i[C_CAPT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) trig_q <= 1'b0;
    else         trig_q <= wr_ctrl && wdata_i[C_TRIG];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              div_q <= DIV_W'(DIV_RST);
    else if (wr_i && addr_i == AW'(A_DIV))    div_q <= wdata_i[DIV_W-1:0];
  end

  for (genvar h = 0; h < HALVES; h++) begin : g_half
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        stage_q[h*DW +: DW] <= '0;
      else if (wr_i && addr_i == AW'(A_STG_LO + h))
        stage_q[h*DW +: DW] <= wdata_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        cap_q[h*DW +: DW] <= '0;
      else if (cap_now)
        cap_q[h*DW +: DW] <= cnt[h*DW +: DW];
      else if (wr_i && addr_i == AW'(A_CAP_LO + h))
        cap_q[h*DW +: DW] <= wdata_i;
    end
  end

  susres_div #(.DIV_W(DIV_W)) u_div (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (tick_en_i),
    .clr_i    (load_ok),
    .period_i (div_q),
    .tick_o   (ms_tick)
  );

  susres_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (ms_tick),
    .load_i     (load_ok),
    .load_val_i (stage_q),
    .cnt_o      (cnt)
  );

  susres_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .trig_i     (trig_q),
    .load_ok_i  (load_ok),
    .load_rej_i (load_rej),
    .clr_pend_i (wr_stat && wdata_i[S_PEND]),
    .clr_err_i  (wr_stat && wdata_i[S_ERR]),
    .arm_i      (wr_ctrl && wdata_i[C_ARM]),
    .pend_o     (pend),
    .reason_o   (reason),
    .err_o      (err),
    .armed_o    (armed)
  );

  always_comb begin
    stat_w          = '0;
    stat_w[S_PEND]  = pend;
    stat_w[2:1]     = reason;
    stat_w[S_ERR]   = err;
    stat_w[S_ARMED] = armed;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q  <= '0;
      shadow_q <= '0;
    end else if (rd_i) begin
      unique case (int'(addr_i))
        A_STAT:   rdata_q <= stat_w;
        A_CNT_LO: begin
          rdata_q  <= cnt[DW-1:0];
          shadow_q <= cnt[CNT_W-1:DW];
        end
        A_CNT_HI: rdata_q <= shadow_q;
        A_CAP_LO: rdata_q <= cap_q[DW-1:0];
        A_CAP_HI: rdata_q <= cap_q[CNT_W-1:DW];
        A_STG_LO: rdata_q <= stage_q[DW-1:0];
        A_STG_HI: rdata_q <= stage_q[CNT_W-1:DW];
        A_DIV:    rdata_q <= DW'(div_q);
        default:  rdata_q <= '0;
      endcase
    end
  end

  assign rdata_o = rdata_q;
  assign irq_o   = pend;
endmodule

// File: rtl/susres_timer_chk.sv
module susres_timer_chk #(
  parameter int CNT_W = 64
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             irq_o,
  input logic             trig_q,
  input logic             load_ok,
  input logic             armed,
  input logic [1:0]       reason,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] cap_q,
  input logic [CNT_W-1:0] stage_q
);
  logic seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 1'b0;
    else         seen_q <= 1'b1;
  end

  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && !$past(load_ok)) |-> (cnt == $past(cnt) || cnt == $past(cnt) + 1'b1)); // R2
  AST_TRIG_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_q |=> irq_o); // R3
  AST_IRQ_REASON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (reason != 2'b00)); // R3
  AST_LOAD_COMMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_ok |=> (cnt == $past(stage_q))); // R5
  AST_ARM_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed |=> armed); // R8
  AST_ARM_FLOOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && load_ok) |=> (cnt >= $past(cap_q))); // R8
endmodule

bind susres_timer susres_timer_chk #(.CNT_W(2 * DW)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .irq_o   (irq_o),
  .trig_q  (trig_q),
  .load_ok (load_ok),
  .armed   (armed),
  .reason  (reason),
  .cnt     (cnt),
  .cap_q   (cap_q),
  .stage_q (stage_q)
);

// File: tb/susres_timer_tb_top.sv
module susres_timer_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        wr = 1'b0;
  logic        rd = 1'b0;
  logic [31:0] rdata;
  logic        irq;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  susres_timer dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_en_i(tick_en), .addr_i(addr),
    .wdata_i(wdata), .wr_i(wr), .rd_i(rd), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input int a, input logic [31:0] d);
    @(negedge clk); addr = 4'(a); wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
    @(negedge clk);
  endtask

  task automatic bus_rd(input int a, output logic [31:0] d);
    @(negedge clk); addr = 4'(a); rd = 1'b1;
    @(negedge clk); rd = 1'b0; d = rdata;
  endtask

  task automatic rd_cnt(output logic [63:0] v);
    logic [31:0] lo, hi;
    bus_rd(2, lo);
    bus_rd(3, hi);
    v = {hi, lo};
  endtask

  task automatic load64(input logic [63:0] v);
    bus_wr(6, v[31:0]);
    bus_wr(7, v[63:32]);
    bus_wr(0, 32'h2);
  endtask

  task automatic run(input int k);
    @(negedge clk); tick_en = 1'b1;
    repeat (k) @(posedge clk);
    @(negedge clk); tick_en = 1'b0;
  endtask

  function automatic logic [63:0] exp_after(input logic [63:0] base, input int k, input int div);
    return base + 64'(k / (div + 1));
  endfunction

  function automatic logic [31:0] stat_word(input bit pend, input int rsn, input bit err, input bit armed);
    return {27'd0, armed, err, 2'(rsn), pend};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [63:0] v;
    int seed;
    seed = $urandom(32'd20210602);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    bus_rd(1, d);  check("R1 status", 64'(d), 64'(0));
    rd_cnt(v);     check("R1 count", v, 64'(0));
    check("R1 irq", 64'(irq), 64'(0));

    // R2 divider, hold
    bus_wr(8, 32'd3);
    run(20);
    rd_cnt(v);     check("R2 ticks div3", v, exp_after(64'd0, 20, 3));
    repeat (10) @(negedge clk);
    rd_cnt(v);     check("R2 hold enable low", v, 64'd5);

    // R3 trigger, R4 clear
    bus_wr(0, 32'h1);
    bus_rd(1, d);  check("R3 suspend status", 64'(d), 64'(stat_word(1, 1, 0, 0)));
    check("R3 irq high", 64'(irq), 64'(1));
    bus_wr(1, 32'h0);
    bus_rd(1, d);  check("R4 write zero ignored", 64'(d), 64'(stat_word(1, 1, 0, 0)));
    bus_wr(1, 32'h1);
    bus_rd(1, d);  check("R4 cleared", 64'(d), 64'(0));
    check("R4 irq low", 64'(irq), 64'(0));

    // R5 + R2 random loads and tick runs
    for (int i = 0; i < 16; i++) begin
      logic [63:0] val;
      int div, k;
      val = {$urandom, $urandom};
      div = int'($urandom % 5);
      k   = int'($urandom % 40) + 1;
      load64(val);
      bus_rd(1, d);  check("R5 resume status", 64'(d), 64'(stat_word(1, 2, 0, 0)));
      rd_cnt(v);     check("R5 load value", v, val);
      bus_wr(1, 32'h1);
      bus_wr(8, 32'(div));
      run(k);
      rd_cnt(v);     check("R2 random run", v, exp_after(val, k, div));
    end

    // R6 shadow across carry into high word
    bus_wr(8, 32'd0);
    load64(64'h0000_0000_FFFF_FFFF);
    bus_rd(2, d);  check("R6 low before carry", 64'(d), 64'hFFFF_FFFF);
    run(1);
    bus_rd(3, d);  check("R6 shadow kept", 64'(d), 64'(0));
    bus_rd(2, d);  check("R6 low after carry", 64'(d), 64'(0));
    bus_rd(3, d);  check("R6 high after carry", 64'(d), 64'(1));

    // R7 capture and direct write
    load64(64'd1000);
    bus_wr(0, 32'h4);
    bus_rd(4, d);  check("R7 capture low", 64'(d), 64'd1000);
    bus_rd(5, d);  check("R7 capture high", 64'(d), 64'(0));
    bus_wr(5, 32'd5);
    bus_rd(5, d);  check("R7 direct write", 64'(d), 64'd5);
    bus_wr(5, 32'd0);

    // R8 arm, refuse below floor
    bus_wr(1, 32'h1);
    bus_wr(0, 32'h8);
    bus_rd(1, d);  check("R8 armed", 64'(d), 64'(stat_word(0, 0, 0, 1)));
    load64(64'd999);
    rd_cnt(v);     check("R8 refused count", v, 64'd1000);
    bus_rd(1, d);  check("R8 error set", 64'(d), 64'(stat_word(0, 0, 1, 1)));
    load64(64'd1001);
    rd_cnt(v);     check("R8 above floor", v, 64'd1001);
    bus_rd(1, d);  check("R8 status after accept", 64'(d), 64'(stat_word(1, 2, 1, 1)));
    bus_wr(1, 32'h9);
    bus_wr(0, 32'h0);
    bus_rd(1, d);  check("R8 armed sticky", 64'(d), 64'(stat_word(0, 0, 0, 1)));
    load64(64'd1000);
    rd_cnt(v);     check("R8 equal accepted", v, 64'd1000);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule